// File: doc/BRIEF.md
# Prefix-Based Pipeline Selector

This block is the entry stage of a lookup engine that spreads its search tree over several parallel pipelines. Every incoming address is split at its top `SEL_W` bits. Those bits index a selection table. Each table entry either names one of `P` downstream search pipelines and a root node pointer inside that pipeline, or marks the slot as empty. The subtrees held by the pipelines do not overlap, so exactly one pipeline, or none, receives each lookup.

Prefixes shorter than `SEL_W` bits cannot be placed in any single subtree. They are resolved here, using a flat bitmap that holds one bit per possible short prefix. The longest short prefix that matches is reported as a fallback result. A deeper pipeline result, when one arrives later, overrides this fallback. A configuration port writes table entries and bitmap bits. The stage accepts a new address every cycle and produces its result one cycle later.

The nominal selection width is 16 bits. The default parameter is 8 bits, which keeps the stored tables small at elaboration.

Top module: `prefix_pipe_selector`

## Requirements
- R1: After reset, every output is 0, every table entry is empty and every bitmap bit is clear. A lookup made before any configuration therefore yields `pipe_valid`=0 and `short_hit`=0.
- R2: A lookup presented with `in_valid`=1 at a clock edge appears at that edge's outputs. At that point `out_valid`=1 and `out_addr` equals the presented address. One lookup is accepted every cycle, with no gaps.
- R3: The entry used is the one indexed by address bits [ADDR_W-1 -: SEL_W]. For a non-empty entry, `pipe_sel` and `pipe_root` equal that entry's stored pipeline number and root pointer.
- R4: `pipe_req` is 1 only at bit `pipe_sel`, and only while `pipe_valid`=1. Otherwise `pipe_req` is all zeros.
- R5: A lookup that hits an empty entry gives `pipe_valid`=0, `pipe_req`=0, `pipe_sel`=0 and `pipe_root`=0. It still gives `out_valid`=1 and the short-prefix result.
- R6: The short prefix of length l (0 ≤ l < SEL_W) with value v, which is the top l address bits, lives at bitmap index (2^l − 1) + v. `short_hit`=1 when any such bit is set for the address. `short_len` is then the largest matching l.
- R7: The length-0 bit (index 0) matches every address, so it serves as a default route with `short_len`=0.
- R8: A table write (`cfg_target`=0) takes `cfg_data` as {empty[ROOT_W+PIPE_W], pipe[ROOT_W+PIPE_W-1:ROOT_W], root[ROOT_W-1:0]} at index `cfg_index`. Lookups in later cycles see the new entry. A lookup in the same cycle as the write still sees the old entry.
- R9: A bitmap write (`cfg_target`=1) sets bit `cfg_index` to `cfg_data[0]`, so writing 0 clears a prefix. A bitmap write leaves the table unchanged, and a table write leaves the bitmap unchanged.
- R10: In a cycle with `out_valid`=0, the outputs `out_addr`, `pipe_valid`, `pipe_sel`, `pipe_root`, `pipe_req`, `short_hit` and `short_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | ADDR_W | Address to look up |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 1 | 0 = selection table, 1 = short-prefix bitmap |
| cfg_index | input | SEL_W | Table entry or bitmap bit index |
| cfg_data | input | ROOT_W+PIPE_W+1 | Entry fields, or bit value in bit 0 |
| out_valid | output | 1 | Result of a lookup is present |
| out_addr | output | ADDR_W | Forwarded address |
| pipe_valid | output | 1 | A pipeline was chosen |
| pipe_sel | output | PIPE_W | Chosen pipeline number |
| pipe_root | output | ROOT_W | Root node pointer in the chosen pipeline |
| pipe_req | output | P | One request line per pipeline |
| short_hit | output | 1 | A short prefix matched |
| short_len | output | LEN_W | Length of the longest matching short prefix |

## Verification
The assertions assume that `in_valid` and `cfg_we` are always known levels. They also assume that every table entry marked non-empty carries a pipeline number below `P`. With the default `P`=4 and 2-bit pipeline field, every code is legal. The stimulus changes inputs only at the falling edge and writes only fully specified entries. It mixes table writes, bitmap sets and clears, and a write that coincides with a lookup to the same entry. It drives back-to-back lookups under a valid pattern that switches between on and off, so the latency and idle-quiet properties are exercised on every cycle.

// File: rtl/psel_pkg.sv
package psel_pkg;

    typedef enum logic {
        CFG_TABLE  = 1'b0,
        CFG_BITMAP = 1'b1
    } cfg_target_e;

endpackage

// File: rtl/psel_table.sv
module psel_table #(
    parameter int SEL_W  = 8,
    parameter int PIPE_W = 2,
    parameter int ROOT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic              wr_empty,
    input  logic [PIPE_W-1:0] wr_pipe,
    input  logic [ROOT_W-1:0] wr_root,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic              rd_empty,
    output logic [PIPE_W-1:0] rd_pipe,
    output logic [ROOT_W-1:0] rd_root
);

    localparam int DEPTH = 2 ** SEL_W;

    logic [DEPTH-1:0]  empty_q;
    logic [PIPE_W-1:0] pipe_q [DEPTH];
    logic [ROOT_W-1:0] root_q [DEPTH];

    // Only the empty flags need a reset value; payload is never
    // forwarded from an empty slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= '1;
        end else if (wr_en) begin
            empty_q[wr_idx] <= wr_empty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pipe_q[wr_idx] <= wr_pipe;
            root_q[wr_idx] <= wr_root;
        end
    end

    assign rd_empty = empty_q[rd_idx];
    assign rd_pipe  = pipe_q[rd_idx];
    assign rd_root  = root_q[rd_idx];

endmodule

// File: rtl/psel_bitmap.sv
module psel_bitmap #(
    parameter int SEL_W = 8,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [SEL_W-1:0] key,
    output logic             hit,
    output logic [LEN_W-1:0] len
);

    // One bit per prefix of length 0 .. SEL_W-1.
    localparam int BM_BITS = (2 ** SEL_W) - 1;

    logic [BM_BITS-1:0] bm_q;
    logic [SEL_W-1:0]   lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bm_q <= '0;
        end else if (wr_en && (int'(wr_idx) < BM_BITS)) begin
            bm_q[wr_idx] <= wr_bit;
        end
    end

    // Per-length probe: base offset of the level plus the top l key bits.
    for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
        localparam logic [SEL_W-1:0] BASE = SEL_W'((1 << l) - 1);
        logic [SEL_W-1:0] probe;
        assign probe      = BASE + (key >> (SEL_W - l));
        assign lvl_hit[l] = bm_q[probe];
    end

    // Longest match wins: later (longer) levels overwrite shorter ones.
    always_comb begin
        hit = |lvl_hit;
        len = '0;
        for (int l = 0; l < SEL_W; l++) begin
            if (lvl_hit[l]) begin
                len = LEN_W'(l);
            end
        end
    end

endmodule

// File: rtl/prefix_pipe_selector.sv
module prefix_pipe_selector
    import psel_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 8,
    parameter int P      = 4,
    parameter int ROOT_W = 10,
    localparam int PIPE_W = (P > 1) ? $clog2(P) : 1,
    localparam int LEN_W  = (SEL_W > 1) ? $clog2(SEL_W) : 1,
    localparam int CFG_W  = ROOT_W + PIPE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              cfg_we,
    input  logic              cfg_target,
    input  logic [SEL_W-1:0]  cfg_index,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              pipe_valid,
    output logic [PIPE_W-1:0] pipe_sel,
    output logic [ROOT_W-1:0] pipe_root,
    output logic [P-1:0]      pipe_req,
    output logic              short_hit,
    output logic [LEN_W-1:0]  short_len
);

    cfg_target_e       tgt;
    logic              tbl_we, bm_we;
    logic [SEL_W-1:0]  key;
    logic              ent_empty, ent_usable;
    logic [PIPE_W-1:0] ent_pipe;
    logic [ROOT_W-1:0] ent_root;
    logic              bm_hit;
    logic [LEN_W-1:0]  bm_len;

    assign tgt    = cfg_target_e'(cfg_target);
    assign tbl_we = cfg_we && (tgt == CFG_TABLE);
    assign bm_we  = cfg_we && (tgt == CFG_BITMAP);
    assign key    = in_addr[ADDR_W-1 -: SEL_W];

    psel_table #(
        .SEL_W (SEL_W),
        .PIPE_W(PIPE_W),
        .ROOT_W(ROOT_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (cfg_index),
        .wr_empty(cfg_data[ROOT_W+PIPE_W]),
        .wr_pipe (cfg_data[ROOT_W +: PIPE_W]),
        .wr_root (cfg_data[ROOT_W-1:0]),
        .rd_idx  (key),
        .rd_empty(ent_empty),
        .rd_pipe (ent_pipe),
        .rd_root (ent_root)
    );

    psel_bitmap #(
        .SEL_W(SEL_W),
        .LEN_W(LEN_W)
    ) bitmap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bm_we),
        .wr_idx(cfg_index),
        .wr_bit(cfg_data[0]),
        .key   (key),
        .hit   (bm_hit),
        .len   (bm_len)
    );

    // A pipeline number outside 0..P-1 is treated like an empty slot.
    assign ent_usable = !ent_empty && (int'(ent_pipe) < P);

    // Single result stage register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            pipe_valid <= 1'b0;
            pipe_sel   <= '0;
            pipe_root  <= '0;
            short_hit  <= 1'b0;
            short_len  <= '0;
        end else begin
            out_valid  <= in_valid;
            out_addr   <= in_valid ? in_addr : '0;
            pipe_valid <= in_valid && ent_usable;
            pipe_sel   <= (in_valid && ent_usable) ? ent_pipe : '0;
            pipe_root  <= (in_valid && ent_usable) ? ent_root : '0;
            short_hit  <= in_valid && bm_hit;
            short_len  <= (in_valid && bm_hit) ? bm_len : '0;
        end
    end

    for (genvar p = 0; p < P; p++) begin : g_req
        assign pipe_req[p] = pipe_valid && (pipe_sel == PIPE_W'(p));
    end

endmodule

// File: rtl/prefix_pipe_selector_chk.sv
module prefix_pipe_selector_chk #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 8,
    parameter int P      = 4,
    parameter int ROOT_W = 10,
    parameter int PIPE_W = 2,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              pipe_valid,
    input logic [PIPE_W-1:0] pipe_sel,
    input logic [ROOT_W-1:0] pipe_root,
    input logic [P-1:0]      pipe_req,
    input logic              short_hit,
    input logic [LEN_W-1:0]  short_len
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_addr_forward: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_addr == $past(in_addr)));

    a_r4_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pipe_req));

    a_r4_req_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_valid == ($countones(pipe_req) == 1));

    a_r3_pipe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_valid |-> (int'(pipe_sel) < P));

    a_r5_pipe_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_valid |-> out_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!pipe_valid && !short_hit && short_len == '0
                        && pipe_root == '0 && out_addr == '0));

    a_r6_len_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !short_hit |-> (short_len == '0));

endmodule

bind prefix_pipe_selector prefix_pipe_selector_chk #(
    .ADDR_W(ADDR_W),
    .SEL_W (SEL_W),
    .P     (P),
    .ROOT_W(ROOT_W),
    .PIPE_W(PIPE_W),
    .LEN_W (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .pipe_valid(pipe_valid),
    .pipe_sel  (pipe_sel),
    .pipe_root (pipe_root),
    .pipe_req  (pipe_req),
    .short_hit (short_hit),
    .short_len (short_len)
);

// File: tb/prefix_pipe_selector_tb_top.sv
module prefix_pipe_selector_tb_top;

    localparam int NENT = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_target = 1'b0;
    logic [7:0]  cfg_index = '0;
    logic [12:0] cfg_data = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        pipe_valid;
    logic [1:0]  pipe_sel;
    logic [9:0]  pipe_root;
    logic [3:0]  pipe_req;
    logic        short_hit;
    logic [2:0]  short_len;

    always #5 clk = ~clk;

    prefix_pipe_selector dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .cfg_we    (cfg_we),
        .cfg_target(cfg_target),
        .cfg_index (cfg_index),
        .cfg_data  (cfg_data),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .pipe_valid(pipe_valid),
        .pipe_sel  (pipe_sel),
        .pipe_root (pipe_root),
        .pipe_req  (pipe_req),
        .short_hit (short_hit),
        .short_len (short_len)
    );

    typedef struct {
        logic [31:0] ov, oa, pv, ps, pr, pq, sh, sl;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // Reference state, updated from the requirement text.
    bit       m_empty [NENT];
    bit [1:0] m_pipe  [NENT];
    bit [9:0] m_root  [NENT];
    bit       m_bm    [NENT-1];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic v, input logic [31:0] a, input string tag);
        exp_t e;
        int   sel;
        bit   pv;
        sel   = int'(a[31:24]);
        pv    = v && !m_empty[sel];
        e.tag = tag;
        e.ov  = {31'b0, v};
        e.oa  = v ? a : 32'h0;
        e.pv  = {31'b0, pv};
        e.ps  = pv ? 32'(m_pipe[sel]) : 32'h0;
        e.pr  = pv ? 32'(m_root[sel]) : 32'h0;
        e.pq  = pv ? (32'h1 << m_pipe[sel]) : 32'h0;
        e.sh  = 32'h0;
        e.sl  = 32'h0;
        if (v) begin
            for (int l = 0; l < 8; l++) begin
                int ix;
                ix = (1 << l) - 1 + (sel >> (8 - l));
                if (m_bm[ix]) begin
                    e.sh = 32'h1;
                    e.sl = 32'(l);
                end
            end
        end
        return e;
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic we,
                        input logic tgt, input logic [7:0] idx,
                        input logic [12:0] d, input string tag);
        @(negedge clk);
        in_valid   = v;
        in_addr    = a;
        cfg_we     = we;
        cfg_target = tgt;
        cfg_index  = idx;
        cfg_data   = d;
        sb_q.push_back(model(v, a, tag));   // sees the pre-write contents (R8)
        if (we) begin
            if (!tgt) begin
                m_empty[idx] = d[12];
                m_pipe[idx]  = d[11:10];
                m_root[idx]  = d[9:0];
            end else if (idx != 8'hFF) begin
                m_bm[idx] = d[0];
            end
        end
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        step(1'b1, a, 1'b0, 1'b0, 8'h0, 13'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'h0, 1'b0, 1'b0, 8'h0, 13'h0, tag);
    endtask

    task automatic wr_tbl(input logic [7:0] sel, input logic e, input logic [1:0] p,
                          input logic [9:0] r);
        step(1'b0, 32'h0, 1'b1, 1'b0, sel, {e, p, r}, "R10");
    endtask

    task automatic wr_bm(input logic [7:0] ix, input logic b);
        step(1'b0, 32'h0, 1'b1, 1'b1, ix, {12'h0, b}, "R10");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: one scoreboard item per cycle, compared just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "out_valid",  32'(out_valid),  e.ov);
                chk(e.tag, "out_addr",   out_addr,        e.oa);
                chk(e.tag, "pipe_valid", 32'(pipe_valid), e.pv);
                chk(e.tag, "pipe_sel",   32'(pipe_sel),   e.ps);
                chk(e.tag, "pipe_root",  32'(pipe_root),  e.pr);
                chk(e.tag, "pipe_req",   32'(pipe_req),   e.pq);
                chk(e.tag, "short_hit",  32'(short_hit),  e.sh);
                chk(e.tag, "short_len",  32'(short_len),  e.sl);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < NENT; i++) begin
            m_empty[i] = 1'b1;
            m_pipe[i]  = '0;
            m_root[i]  = '0;
        end
        for (int i = 0; i < NENT - 1; i++) m_bm[i] = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state at the ports
        chk("R1", "out_valid",  32'(out_valid),  32'h0);
        chk("R1", "pipe_req",   32'(pipe_req),   32'h0);
        chk("R1", "short_hit",  32'(short_hit),  32'h0);
        chk("R1", "pipe_valid", 32'(pipe_valid), 32'h0);

        look(32'hC0A8_0001, "R1");          // unconfigured: empty, no short hit
        idle("R10");

        wr_tbl(8'hC0, 1'b0, 2'd2, 10'h155);
        wr_tbl(8'h0A, 1'b0, 2'd0, 10'h3FF);
        wr_tbl(8'hFF, 1'b0, 2'd3, 10'h001);

        // R3 / R4 back-to-back lookups, one per cycle (R2)
        look(32'hC012_3456, "R3");
        look(32'h0A00_0001, "R4");
        look(32'hFFFF_FFFF, "R3");
        look(32'h0B00_0000, "R5");
        idle("R10");

        // R7: default route at index 0
        wr_bm(8'd0, 1'b1);
        look(32'h0B00_0000, "R7");
        // R6: length-3 prefix 101 -> index 7+5 = 12
        wr_bm(8'd12, 1'b1);
        look(32'hA000_0000, "R6");
        look(32'hC000_0000, "R6");
        // R6: length-7 prefix 1011001 -> index 127+89 = 216
        wr_bm(8'd216, 1'b1);
        look(32'hB300_0000, "R6");
        look(32'hB400_0000, "R6");
        look(32'hB200_0000, "R6");

        // R8: write and lookup to the same entry in one cycle
        step(1'b1, 32'h0B11_2233, 1'b1, 1'b0, 8'h0B, {1'b0, 2'd1, 10'h0AA}, "R8");
        look(32'h0B00_0000, "R8");

        // R9: clearing a bit, and the two stores staying separate
        wr_bm(8'd12, 1'b0);
        look(32'hB400_0000, "R9");
        wr_bm(8'h0A, 1'b1);                 // length-3 prefix 011
        look(32'h0A00_0000, "R9");
        look(32'h6000_0000, "R9");
        wr_tbl(8'h00, 1'b0, 2'd1, 10'h2C3);
        look(32'h0000_0000, "R9");

        // R5: re-marking an entry empty
        wr_tbl(8'hFF, 1'b1, 2'd3, 10'h001);
        look(32'hFF00_0000, "R5");

        // R2: pseudo-random stream with a varying valid pattern
        lcg = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[3:0] < 4'd3) idle("R10");
            else                 look(lcg, "R2");
        end
        idle("R10");
        idle("R10");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule